// File: doc/BRIEF.md
# Register-Pair Load/Store Sequencer

This execution unit serves an RV32 core. It moves 64-bit values between an even/odd pair of 32-bit architectural registers and a memory port that is 64 bits wide. A request names the operation (load or store), the value of the base register, an unsigned byte offset and the pair number. The unit adds the offset to the base to form the address and issues a single 64-bit memory access. When a load completes, the unit writes the two 32-bit halves into the pair through one register-file write port over two consecutive cycles. For a store, the unit reads both registers of the pair through two combinational read ports when it accepts the request and sends them as one 64-bit word.

The unit handles one instruction at a time. It accepts a request only while idle and reports completion with a one-cycle pulse that carries fault and illegal flags. When the pair-access feature is switched off, the request completes with the illegal flag set and no memory traffic. When the memory returns an error, the sequence stops before any register write and completes with the fault flag set. Pair 0 (x0/x1) is handled as a zero source: a load into it writes nothing, and a store from it sends all-zero data.

Top module: `pair_lsu`

## Requirements
- R1: The memory address equals `req_base` plus `req_off` zero-extended to the address width, modulo 2^32.
- R2: A successful load writes register 2p with memory bits [31:0] in the first write cycle, then writes register 2p+1 with bits [63:32] in the next cycle, where p is `req_pair` and the write address is `{p, half}`.
- R3: The store data equals `{reg(2p+1), reg(2p)}`, with the even register in bits [31:0] and the odd register in bits [63:32].
- R4: Each enabled instruction issues exactly one memory request. Its byte strobe is all ones (8'hFF), and `mem_we` is 1 for a store and 0 for a load.
- R5: With `ext_en` low, an accepted request completes with `done_illegal`=1. It makes no memory request and no register write.
- R6: `req_ready` is high when idle. It stays low from the cycle after acceptance until the cycle after the completion pulse, which covers both load write cycles.
- R7: A memory response with `mem_rsp_err`=1 ends the sequence with `done_fault`=1 and no register write.
- R8: A load into pair 0 performs the memory read but writes no register. A store from pair 0 writes 64'h0, whatever the read ports return.
- R9: After reset, `req_ready`=1 and `mem_req_valid`, `rf_we` and `done_valid` are all 0.
- R10: Completion is signalled by `done_valid` high for exactly one cycle. On a successful access both `done_fault` and `done_illegal` are 0.
- R11: While `mem_req_ready` is low, the pending request stays asserted and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_en | input | 1 | Pair-access feature enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and able to accept |
| req_store | input | 1 | 1 = store, 0 = load |
| req_base | input | 32 | Base register value |
| req_off | input | 12 | Unsigned byte offset |
| req_pair | input | 4 | Pair number p (registers 2p, 2p+1) |
| rf_raddr_even | output | 5 | Read address of even register |
| rf_raddr_odd | output | 5 | Read address of odd register |
| rf_rdata_even | input | 32 | Even register value |
| rf_rdata_odd | input | 32 | Odd register value |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 5 | Register write address |
| rf_wdata | output | 32 | Register write data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 64 | Store data |
| mem_strb | output | 8 | Byte strobes |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_data | input | 64 | Load data |
| mem_rsp_err | input | 1 | Memory error response |
| done_valid | output | 1 | Completion pulse |
| done_fault | output | 1 | Completion carried a memory error |
| done_illegal | output | 1 | Completion rejected as illegal |

## Verification
The bench sweeps every pair number with both operations. Odd pairs run while the memory stalls, and the offsets include one that wraps the address past 2^32. A unit that swapped the halves or the write order would put the wrong word into register 2p, and a unit that concatenated the store data backwards would send the odd register in the low bits. Pair 0 is covered with read ports that return non-zero garbage, so a unit without the x0 rule would write x0/x1 or leak that garbage into memory. The remaining cases are a disabled feature and an error response on a load and on a store. A unit that ignored either one would raise a memory request or write registers before reporting.

// File: rtl/pair_lsu.sv
module pair_lsu #(
  parameter int XLEN = 32,
  parameter int OFFW = 12,
  parameter int PW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_store,
  input  logic [XLEN-1:0]   req_base,
  input  logic [OFFW-1:0]   req_off,
  input  logic [PW-1:0]     req_pair,
  output logic [PW:0]       rf_raddr_even,
  output logic [PW:0]       rf_raddr_odd,
  input  logic [XLEN-1:0]   rf_rdata_even,
  input  logic [XLEN-1:0]   rf_rdata_odd,
  output logic              rf_we,
  output logic [PW:0]       rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [2*XLEN-1:0] mem_wdata,
  output logic [XLEN/4-1:0] mem_strb,
  input  logic              mem_rsp_valid,
  input  logic [2*XLEN-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              done_valid,
  output logic              done_fault,
  output logic              done_illegal
);
  localparam int DW = 2 * XLEN;

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_WLO, S_WHI, S_DONE} state_t;

  state_t          st;
  logic            store_q, fault_q, illegal_q;
  logic [PW-1:0]   pair_q;
  logic [XLEN-1:0] addr_q;
  logic [DW-1:0]   data_q;

  wire accept  = req_valid && (st == S_IDLE);
  wire zero_pr = (pair_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      store_q   <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
      pair_q    <= '0;
      addr_q    <= '0;
      data_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          store_q   <= req_store;
          pair_q    <= req_pair;
          addr_q    <= req_base + {{(XLEN-OFFW){1'b0}}, req_off};
          data_q    <= (req_pair == '0) ? '0 : {rf_rdata_odd, rf_rdata_even};
          fault_q   <= 1'b0;
          illegal_q <= !ext_en;
          st        <= ext_en ? S_ISSUE : S_DONE;
        end
        S_ISSUE: if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            fault_q <= 1'b1;
            st      <= S_DONE;
          end else if (store_q) begin
            st <= S_DONE;
          end else begin
            data_q <= mem_rsp_data;
            st     <= S_WLO;
          end
        end
        S_WLO:   st <= S_WHI;
        S_WHI:   st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign rf_raddr_even = {req_pair, 1'b0};
  assign rf_raddr_odd  = {req_pair, 1'b1};

  assign mem_req_valid = (st == S_ISSUE);
  assign mem_we        = store_q;
  assign mem_addr      = addr_q;
  assign mem_wdata     = data_q;
  assign mem_strb      = '1;

  assign rf_we    = ((st == S_WLO) || (st == S_WHI)) && !zero_pr;
  assign rf_waddr = {pair_q, st == S_WHI};
  assign rf_wdata = (st == S_WHI) ? data_q[DW-1:XLEN] : data_q[XLEN-1:0];

  assign done_valid   = (st == S_DONE);
  assign done_fault   = fault_q;
  assign done_illegal = illegal_q;

  AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)); // R11
  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R4
  AST_EVEN_THEN_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !rf_waddr[0] |=> rf_we && rf_waddr[0] && (rf_waddr[PW:1] == $past(rf_waddr[PW:1]))); // R2
  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !req_ready); // R6
  AST_ILLEGAL_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !ext_en |=> !mem_req_valid && done_valid && done_illegal); // R5
  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid && mem_rsp_err && !req_ready |=> !rf_we && done_valid && done_fault); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready); // R10
endmodule

// File: tb/sim_pair_lsu.sv
`timescale 1ns/1ps
module sim_pair_lsu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        ext_en, req_valid, req_ready, req_store;
  logic [31:0] req_base;
  logic [11:0] req_off;
  logic [3:0]  req_pair;
  logic [4:0]  rf_raddr_even, rf_raddr_odd, rf_waddr;
  logic [31:0] rf_rdata_even, rf_rdata_odd, rf_wdata;
  logic        rf_we, mem_req_valid, mem_req_ready, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata, mem_rsp_data;
  logic [7:0]  mem_strb;
  logic        mem_rsp_valid, mem_rsp_err;
  logic        done_valid, done_fault, done_illegal;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit stall = 0, err_inj = 0;

  int          acc_n;
  logic [31:0] acc_addr;
  logic [63:0] acc_wdata;
  logic [7:0]  acc_strb;
  logic        acc_we;
  int          wr_n;
  logic [4:0]  wr_addr [4];
  logic [31:0] wr_data [4];

  function automatic logic [31:0] regval(input logic [4:0] i);
    return (i == 0 || i == 1) ? 32'hBAD0_0BAD : ({27'd0, i} * 32'h0101_0101) ^ 32'h1357_9BDF;
  endfunction
  function automatic logic [63:0] memval(input logic [31:0] a);
    return {a ^ 32'h5A5A_A5A5, ~a};
  endfunction

  assign rf_rdata_even = regval(rf_raddr_even);
  assign rf_rdata_odd  = regval(rf_raddr_odd);
  assign mem_req_ready = !stall || cyc[0];

  pair_lsu u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      acc_n        <= acc_n + 1;
      acc_addr     <= mem_addr;
      acc_wdata    <= mem_wdata;
      acc_strb     <= mem_strb;
      acc_we       <= mem_we;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= memval(mem_addr);
      mem_rsp_err   <= err_inj;
    end
    if (rf_we) begin
      if (wr_n < 4) begin
        wr_addr[wr_n] <= rf_waddr;
        wr_data[wr_n] <= rf_wdata;
      end
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input bit st, input logic [31:0] base, input logic [11:0] off,
                        input logic [3:0] p, input bit en, input bit err, input bit stl);
    logic [31:0] ea;
    bit busy_bad;
    int n;
    ea = base + {20'd0, off};
    busy_bad = 0;
    @(negedge clk);
    acc_n = 0; wr_n = 0;
    stall = stl; err_inj = err; ext_en = en;
    req_valid = 1; req_store = st; req_base = base; req_off = off; req_pair = p;
    @(negedge clk);
    req_valid = 0; req_base = 32'hFFFF_FFFF; req_pair = 4'hF;
    n = 0;
    while (!done_valid && n < 60) begin
      if (req_ready) busy_bad = 1;
      @(negedge clk);
      n++;
    end
    chk(done_valid, "R10 done", done_valid, 1);
    chk(!busy_bad && !req_ready, "R6 busy", busy_bad, 0);
    if (!en) begin
      chk(done_illegal && !done_fault, "R5 flags", {done_illegal, done_fault}, 2'b10);
      chk(acc_n == 0 && wr_n == 0, "R5 no access", {acc_n[15:0], wr_n[15:0]}, 0);
    end else if (err) begin
      chk(done_fault && !done_illegal, "R7 flags", {done_illegal, done_fault}, 2'b01);
      chk(wr_n == 0, "R7 no write", wr_n, 0);
      chk(acc_n == 1, "R4 count", acc_n, 1);
    end else begin
      chk(!done_fault && !done_illegal, "R10 flags", {done_illegal, done_fault}, 0);
      chk(acc_n == 1, "R4 count", acc_n, 1);
      chk(acc_strb == 8'hFF && acc_we == st, "R4 strb/we", {acc_we, acc_strb}, {st, 8'hFF});
      chk(acc_addr == ea, "R1 addr", acc_addr, ea);
      if (st) begin
        logic [63:0] ew;
        ew = (p == 0) ? 64'h0 : {regval({p, 1'b1}), regval({p, 1'b0})};
        chk(acc_wdata == ew, (p == 0) ? "R8 store zero" : "R3 store data", acc_wdata, ew);
        chk(wr_n == 0, "R3 no write", wr_n, 0);
      end else if (p == 0) begin
        chk(wr_n == 0, "R8 load x0", wr_n, 0);
      end else begin
        logic [63:0] d;
        d = memval(ea);
        chk(wr_n == 2, "R2 count", wr_n, 2);
        chk(wr_addr[0] == {p, 1'b0} && wr_data[0] == d[31:0], "R2 even",
            {wr_addr[0], wr_data[0]}, {p, 1'b0, d[31:0]});
        chk(wr_addr[1] == {p, 1'b1} && wr_data[1] == d[63:32], "R2 odd",
            {wr_addr[1], wr_data[1]}, {p, 1'b1, d[63:32]});
      end
    end
    @(negedge clk);
    chk(!done_valid && req_ready, "R10 pulse", {done_valid, req_ready}, 2'b01);
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    ext_en = 1; req_valid = 0; req_store = 0; req_base = 0; req_off = 0; req_pair = 0;
    mem_rsp_valid = 0; mem_rsp_data = 0; mem_rsp_err = 0;
    acc_n = 0; wr_n = 0; acc_addr = 0; acc_wdata = 0; acc_strb = 0; acc_we = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !rf_we && !done_valid, "R9 reset",
        {req_ready, mem_req_valid, rf_we, done_valid}, 4'b1000);
    rst_n = 1;
    for (int p = 0; p < 16; p++)
      for (int s = 0; s < 2; s++)
        run_op(s[0], 32'h1000_0000 + p * 32'h0040_0100, 12'((p * 104 + s * 8) % 4096),
               4'(p), 1, 0, p[0]);
    run_op(0, 32'hFFFF_F008, 12'hFFF, 4'd5, 1, 0, 1);   // R1 wrap
    run_op(1, 32'hFFFF_FFF8, 12'h010, 4'd9, 1, 0, 0);   // R1 wrap store
    run_op(0, 32'h2000_0000, 12'h040, 4'd3, 0, 0, 0);   // R5 load
    run_op(1, 32'h2000_0000, 12'h040, 4'd7, 0, 0, 0);   // R5 store
    run_op(0, 32'h3000_0000, 12'h080, 4'd6, 1, 1, 1);   // R7 load
    run_op(1, 32'h3000_0000, 12'h088, 4'd2, 1, 1, 0);   // R7 store
    run_op(0, 32'h4000_0000, 12'h008, 4'd4, 1, 0, 0);   // recovery after fault
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule